// File: doc/BRIEF.md
# Flash Operation Status Responder

This block sits on the read path of a byte-wide flash array model. While an internal program or erase cycle runs, it returns status bytes instead of array contents. Software can poll two completion indicators. The first is a polarity bit that shows the inverse of the most significant bit of the byte being programmed, or a zero during an erase. The second is a bit that flips on every new read access. When the cycle ends, the read path again passes the array data through unchanged.

A cycle starts with a one-cycle start request. The request carries the operation kind, the byte address and the byte value last loaded for programming. The busy period is counted in clock cycles from parameters: one length for programming and one for both erase kinds. For the whole busy period the block raises a drive-low enable, `rdy_pull_lo`. An open-drain pad driven by this enable lets several devices share one wired ready/busy line.

The read data path is combinational from `rd_addr`, `array_data` and the internal state. The toggle state changes only on a rising edge of `rd_strobe`, as seen at the clock.

Top module: `flash_status_responder`

## Requirements
- R1: After reset `rdy_pull_lo` is 0 and `rd_data` equals `array_data`.
- R2: When idle, a start request with kind code 1 (program), 2 (sector erase) or 3 (chip erase) sets `rdy_pull_lo` to 1 from the next clock edge. A request with kind code 0 is ignored and `rdy_pull_lo` stays 0.
- R3: `rdy_pull_lo` stays high for exactly PROG_CYCLES clock edges after a program start. For either erase kind it stays high for exactly ERASE_CYCLES edges. It then returns to 0.
- R4: During a program cycle, a read at the captured address returns the inverse of bit 7 of the captured byte on `rd_data[7]`.
- R5: During a sector or chip erase, every read returns 0 on `rd_data[7]`, at any address.
- R6: While busy, `rd_data[6]` reads 0 at the first read of each cycle. It inverts after every rising edge of `rd_strobe`. Holding `rd_strobe` high does not make it change again.
- R7: While busy, `rd_data[5:0]` is 0. During a program cycle, a read at any other address returns 0 on bit 7.
- R8: Once the cycle ends, `rd_data` equals `array_data` on all bits, and bit 6 no longer changes with new reads.
- R9: A start request made while busy is ignored. The captured address, byte, kind and remaining duration are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | One-cycle request to begin an internal cycle |
| start_kind | input | 2 | Operation: 0 none, 1 program, 2 sector erase, 3 chip erase |
| start_addr | input | ADDR_W | Address of the byte last loaded |
| start_data | input | DATA_W | Value of the byte last loaded |
| rd_strobe | input | 1 | Read access enable; a rising edge counts as a new read |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | DATA_W | Array contents at `rd_addr` |
| rd_data | output | DATA_W | Read result: array data or status byte |
| rdy_pull_lo | output | 1 | Drive-low enable for the shared ready/busy line |

## Verification
Program cycles are run with loaded bytes whose top bit is 0 and with loaded bytes whose top bit is 1. Each is polled at the loaded address and at an unrelated address, which separates a true inversion from a constant and confirms the address match. Sector and chip erase are polled at several addresses to show that bit 7 is forced low whatever the address and kind. Strobe patterns mix distinct pulses with one long held pulse, which separates edge-driven toggling from level- or clock-driven toggling. A late second start, reads after completion, and a start with the empty kind code show that the state is neither restarted nor left running.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_CHIP = 2'd3
    } op_kind_e;
endpackage

// File: rtl/fsr_cycle_timer.sv
module fsr_cycle_timer
    import flash_status_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  op_kind_e          start_kind,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    output logic              busy_o,
    output logic              accept_o,
    output op_kind_e          kind_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        op_kind_e          kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       accept;

    always_comb begin
        st_d   = st_q;
        accept = start_valid && (start_kind != OP_NONE) && !st_q.busy;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.cnt  = (start_kind == OP_PROG) ? CNT_W'(PROG_CYCLES - 1)
                                                : CNT_W'(ERASE_CYCLES - 1);
            st_d.kind = start_kind;
            st_d.addr = start_addr;
            st_d.data = start_data;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, cnt: '0, kind: OP_NONE, addr: '0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = st_q.busy;
    assign accept_o = accept;
    assign kind_o   = st_q.kind;
    assign addr_o   = st_q.addr;
    assign data_o   = st_q.data;
endmodule

// File: rtl/fsr_toggle_track.sv
module fsr_toggle_track (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic busy,
    input  logic rd_strobe,
    output logic toggle_o
);
    typedef struct packed {
        logic strobe_prev;
        logic tog;
    } tog_state_t;

    tog_state_t st_d, st_q;
    logic       rd_rise;

    always_comb begin
        st_d             = st_q;
        rd_rise          = rd_strobe && !st_q.strobe_prev;
        st_d.strobe_prev = rd_strobe;
        if (restart) begin
            st_d.tog = 1'b0;
        end else if (busy && rd_rise) begin
            st_d.tog = !st_q.tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign toggle_o = st_q.tog;
endmodule

// File: rtl/fsr_status_mux.sv
module fsr_status_mux
    import flash_status_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              busy,
    input  op_kind_e          kind,
    input  logic [ADDR_W-1:0] loaded_addr,
    input  logic [DATA_W-1:0] loaded_data,
    input  logic              toggle,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    always_comb begin
        if (!busy) begin
            rd_data = array_data;
        end else begin
            rd_data          = '0;
            rd_data[TOG_BIT] = toggle;
            if (kind == OP_PROG && rd_addr == loaded_addr) begin
                rd_data[POLL_BIT] = !loaded_data[POLL_BIT];
            end
        end
    end
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
    import flash_status_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [1:0]        start_kind,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy_pull_lo
);
    logic              busy_q;
    logic              accept;
    op_kind_e          op_kind_q;
    logic [ADDR_W-1:0] loaded_addr_q;
    logic [DATA_W-1:0] loaded_data_q;
    logic              toggle_q;

    fsr_cycle_timer #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_valid(start_valid),
        .start_kind (op_kind_e'(start_kind)),
        .start_addr (start_addr),
        .start_data (start_data),
        .busy_o     (busy_q),
        .accept_o   (accept),
        .kind_o     (op_kind_q),
        .addr_o     (loaded_addr_q),
        .data_o     (loaded_data_q)
    );

    fsr_toggle_track u_toggle (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept),
        .busy     (busy_q),
        .rd_strobe(rd_strobe),
        .toggle_o (toggle_q)
    );

    fsr_status_mux #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_mux (
        .busy       (busy_q),
        .kind       (op_kind_q),
        .loaded_addr(loaded_addr_q),
        .loaded_data(loaded_data_q),
        .toggle     (toggle_q),
        .rd_addr    (rd_addr),
        .array_data (array_data),
        .rd_data    (rd_data)
    );

    assign rdy_pull_lo = busy_q;
endmodule

// File: rtl/flash_status_responder_sva.sv
module flash_status_responder_sva
    import flash_status_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_valid,
    input logic [1:0]        start_kind,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              rdy_pull_lo,
    input op_kind_e          op_kind_q
);
    AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_pull_lo |-> rd_data == array_data); // R8

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_kind != 2'd0 && !rdy_pull_lo) |=> rdy_pull_lo); // R2

    AST_NONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_kind == 2'd0 && !rdy_pull_lo) |=> !rdy_pull_lo); // R2

    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_pull_lo && op_kind_q != OP_PROG) |-> !rd_data[DATA_W-1]); // R5

    AST_STATUS_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_pull_lo |-> rd_data[DATA_W-3:0] == '0); // R7

    AST_TOGGLE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_pull_lo && rd_strobe && !$past(rd_strobe))
        |=> (!rdy_pull_lo || rd_data[DATA_W-2] != $past(rd_data[DATA_W-2]))); // R6
endmodule

bind flash_status_responder flash_status_responder_sva #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_valid(start_valid),
    .start_kind (start_kind),
    .rd_strobe  (rd_strobe),
    .array_data (array_data),
    .rd_data    (rd_data),
    .rdy_pull_lo(rdy_pull_lo),
    .op_kind_q  (op_kind_q)
);

// File: tb/flash_status_responder_test.sv
module flash_status_responder_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int PROG_N     = 12;
    localparam int ERASE_N    = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_valid = 1'b0;
    logic [1:0]        start_kind = 2'd0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [DATA_W-1:0] start_data = '0;
    logic              rd_strobe = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] array_data;
    logic [DATA_W-1:0] rd_data;
    logic              rdy_pull_lo;

    int tests = 0;
    int fails = 0;
    int busy_cnt = 0;
    bit done = 1'b0;

    assign array_data = rd_addr[7:0] ^ 8'h3C;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rdy_pull_lo) busy_cnt <= busy_cnt + 1;

    flash_status_responder #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_kind(start_kind),
        .start_addr(start_addr), .start_data(start_data), .rd_strobe(rd_strobe),
        .rd_addr(rd_addr), .array_data(array_data), .rd_data(rd_data),
        .rdy_pull_lo(rdy_pull_lo)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [1:0] kind, input logic [15:0] addr, input logic [7:0] data);
        @(negedge clk);
        start_valid = 1'b1; start_kind = kind; start_addr = addr; start_data = data;
        busy_cnt = 0;
        @(negedge clk);
        start_valid = 1'b0; start_kind = 2'd0;
    endtask

    task automatic do_read(input logic [15:0] addr, output logic [7:0] data);
        @(negedge clk);
        rd_strobe = 1'b1; rd_addr = addr;
        #1 data = rd_data;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (rdy_pull_lo && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic t_reset();
        rd_addr = 16'h0042;
        #1;
        check(rdy_pull_lo == 1'b0, "R1 busy after reset", rdy_pull_lo, 0);
        check(rd_data == (8'h42 ^ 8'h3C), "R1 data after reset", rd_data, 8'h42 ^ 8'h3C);
    endtask

    task automatic t_kind_none();
        do_start(2'd0, 16'h0001, 8'hFF);
        check(rdy_pull_lo == 1'b0, "R2 kind 0 ignored", rdy_pull_lo, 0);
        @(negedge clk);
        check(rdy_pull_lo == 1'b0, "R2 kind 0 still idle", rdy_pull_lo, 0);
    endtask

    task automatic t_program(input logic [7:0] val);
        logic [7:0] d;
        do_start(2'd1, 16'h0012, val);
        check(rdy_pull_lo == 1'b1, "R2 program start busy", rdy_pull_lo, 1);
        do_read(16'h0012, d);
        check(d[7] == ~val[7], "R4 poll bit inverted", d[7], ~val[7]);
        check(d[6] == 1'b0, "R6 first read bit6", d[6], 0);
        check(d[5:0] == 6'd0, "R7 low bits zero", d[5:0], 0);
        do_read(16'h0012, d);
        check(d[6] == 1'b1, "R6 second read bit6", d[6], 1);
        check(d[7] == ~val[7], "R4 poll bit repeat", d[7], ~val[7]);
        do_read(16'h0777, d);
        check(d[7] == 1'b0, "R7 other address bit7", d[7], 0);
        check(d[6] == 1'b0, "R6 third read bit6", d[6], 0);
        wait_idle();
        check(busy_cnt == PROG_N, "R3 program duration", busy_cnt, PROG_N);
        do_read(16'h0012, d);
        check(d == (8'h12 ^ 8'h3C), "R8 true data after program", d, 8'h12 ^ 8'h3C);
    endtask

    task automatic t_erase(input logic [1:0] kind);
        logic [7:0] d;
        logic       prev;
        do_start(kind, 16'h0055, 8'h00);
        check(rdy_pull_lo == 1'b1, "R2 erase start busy", rdy_pull_lo, 1);
        prev = 1'b1;
        for (int i = 0; i < 4; i++) begin
            do_read(16'h0055 + 16'(i * 37), d);
            check(d[7] == 1'b0, "R5 erase poll bit", d[7], 0);
            check(d[6] == ~prev, "R6 erase toggle", d[6], ~prev);
            check(d[5:0] == 6'd0, "R7 erase low bits", d[5:0], 0);
            prev = d[6];
        end
        wait_idle();
        check(busy_cnt == ERASE_N, "R3 erase duration", busy_cnt, ERASE_N);
    endtask

    task automatic t_held_strobe();
        logic [7:0] d0;
        do_start(2'd2, 16'h0000, 8'h00);
        @(negedge clk);
        rd_strobe = 1'b1; rd_addr = 16'h0003;
        #1 d0 = rd_data;
        check(d0[6] == 1'b0, "R6 held strobe first", d0[6], 0);
        @(negedge clk);
        #1 check(rd_data[6] == 1'b1, "R6 held strobe one flip", rd_data[6], 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #1 check(rd_data[6] == 1'b1, "R6 held strobe stable", rd_data[6], 1);
        end
        rd_strobe = 1'b0;
        wait_idle();
    endtask

    task automatic t_restart_ignored();
        logic [7:0] d;
        do_start(2'd1, 16'h0020, 8'h80);
        @(negedge clk);
        start_valid = 1'b1; start_kind = 2'd3; start_addr = 16'h0099; start_data = 8'h00;
        @(negedge clk);
        start_valid = 1'b0; start_kind = 2'd0;
        do_read(16'h0020, d);
        check(d[7] == 1'b0, "R9 poll keeps captured byte", d[7], 0);
        check(d[6] == 1'b0, "R9 toggle not restarted", d[6], 0);
        do_read(16'h0099, d);
        check(d[7] == 1'b0, "R9 new address not captured", d[7], 0);
        wait_idle();
        check(busy_cnt == PROG_N, "R9 duration unchanged", busy_cnt, PROG_N);
    endtask

    task automatic t_after_end();
        logic [7:0] d1;
        logic [7:0] d2;
        do_read(16'h00F0, d1);
        do_read(16'h00F0, d2);
        check(d1 == (8'hF0 ^ 8'h3C), "R8 idle data first", d1, 8'hF0 ^ 8'h3C);
        check(d2 == d1, "R8 bit6 steady when idle", d2, d1);
        check(rdy_pull_lo == 1'b0, "R3 released", rdy_pull_lo, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_kind_none();
        t_program(8'h5A);
        t_program(8'hC3);
        t_erase(2'd2);
        t_erase(2'd3);
        t_held_strobe();
        t_restart_ignored();
        t_after_end();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule